// File: doc/BRIEF.md
# Multi-Mode Raster Timing Generator

This block turns one pixel clock into the timing of a 640-dot-wide analog display raster. A horizontal dot counter and a vertical line counter step through each period in a fixed order: sync pulse, back porch, visible region, front porch. From the counter state the block produces the two sync signals, a display-enable flag and the coordinates of the current visible pixel. It also passes the caller's red, green and blue values through, forcing them to zero in every blanking interval. Monitors use the blanked level as their black reference, so the colour is held at zero through both sync pulses and all four porches, not only outside the visible window.

A two-bit select picks one of three vertical formats: 350, 400 or 480 visible lines. Each format has its own sync polarities and vertical porch lengths. The horizontal timing is shared by all three formats. The select is sampled only at the frame wrap, so a change never produces a torn frame. All outputs are registered and come out one clock after the counter state they describe.

Top module: `vga_timing_gen`

## Requirements
- R1: The horizontal counter runs H_SYNC+H_BACK+H_ACTIVE+H_FRONT clocks per line (800 by default). Horizontal sync is asserted for the first H_SYNC clocks, and is followed by the back porch, then H_ACTIVE visible dots, then the front porch.
- R2: The line counter advances once, at the end of each full line. Vertical sync lasts V_SYNC lines and is followed by the back porch, the visible lines and the front porch of the latched format. By default these are 60/350/37 lines for 350-line mode, 35/400/12 for 400-line mode and 33/480/10 for 480-line mode.
- R3: `mode_sel` encoding is 2'b00 for 350 lines, 2'b01 for 400 lines and 2'b10 for 480 lines. Horizontal sync is active-high in 350-line mode and active-low in the other modes.
- R4: Vertical sync is active-low in 350-line mode, active-high in 400-line mode and active-low in 480-line mode.
- R5: `disp_en` is high only when both counters are inside their visible regions. `pix_x` and `pix_y` are (0,0) on the first visible pixel, count up by one per dot and per visible line, and are 0 whenever `disp_en` is low.
- R6: The colour outputs equal the colour inputs while the pixel is visible, and are zero during both sync pulses and all porches.
- R7: `mode_sel` is sampled only in the cycle in which both counters wrap to zero. A change at any other time has no effect until the next frame starts.
- R8: While `rst` is high at a clock edge, both counters clear, `mode_sel` is latched, both syncs go to the inactive level of that mode, and `disp_en`, coordinates and colour go to zero. The first cycle after reset shows the start of the sync pulse.
- R9: Every output is registered and reflects the counter state and the colour inputs of the previous clock edge.
- R10: The select code 2'b11 behaves exactly like the 480-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Vertical format select |
| red_in | input | COLOR_W | Red value for the current pixel |
| green_in | input | COLOR_W | Green value for the current pixel |
| blue_in | input | COLOR_W | Blue value for the current pixel |
| hsync | output | 1 | Horizontal sync, polarity per mode |
| vsync | output | 1 | Vertical sync, polarity per mode |
| disp_en | output | 1 | High on visible pixels |
| pix_x | output | XW | Visible column, 0 outside the visible region |
| pix_y | output | YW | Visible line, 0 outside the visible region |
| red_out | output | COLOR_W | Blanked red |
| green_out | output | COLOR_W | Blanked green |
| blue_out | output | COLOR_W | Blanked blue |

## Verification
Every output is due exactly one clock edge after the counter state and colour inputs it describes. A mode change first shows in the cycle after the edge at which the counters wrap, and reset values appear one edge after `rst` is sampled high. The bench keeps a reference model of the counters and the latched mode. At each edge it computes the outputs the design must present after that edge, then compares them at the following falling edge, well away from the edge that changes them. The bench uses small timing parameters so that many frames, mid-frame mode changes and mid-frame resets all fit in the run.

// File: rtl/vga_mode_pkg.sv
package vga_mode_pkg;

  typedef enum logic [1:0] {
    MODE_L350  = 2'b00,
    MODE_L400  = 2'b01,
    MODE_L480  = 2'b10,
    MODE_L480B = 2'b11
  } mode_t;

  // Active level of horizontal sync: 1 = active-high.
  function automatic logic hs_active_high(input logic [1:0] m);
    return (m == 2'b00);
  endfunction

  // Active level of vertical sync: 1 = active-high.
  function automatic logic vs_active_high(input logic [1:0] m);
    return (m == 2'b01);
  endfunction

  function automatic int imax3(input int a, input int b, input int c);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    return r;
  endfunction

endpackage

// File: rtl/vga_hcount.sv
module vga_hcount #(
  parameter int H_TOTAL = 800,
  parameter int HW      = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_cnt,
  output logic          line_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  assign line_end = (h_cnt == H_LAST);

  always_ff @(posedge clk) begin
    if (rst)           h_cnt <= '0;
    else if (line_end) h_cnt <= '0;
    else               h_cnt <= h_cnt + 1'b1;
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    (h_cnt == H_LAST) |=> (h_cnt == '0));                        // R1
  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    (h_cnt != H_LAST) |=> (h_cnt == $past(h_cnt) + 1'b1));        // R1
endmodule

// File: rtl/vga_vcount.sv
module vga_vcount #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [VW-1:0] v_last,
  output logic [VW-1:0] v_cnt,
  output logic          frame_end
);
  assign frame_end = line_end && (v_cnt == v_last);

  always_ff @(posedge clk) begin
    if (rst)            v_cnt <= '0;
    else if (frame_end) v_cnt <= '0;
    else if (line_end)  v_cnt <= v_cnt + 1'b1;
  end

  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(v_cnt));                                // R2
  AST_V_STEP: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_end) |=> (v_cnt == $past(v_cnt) + 1'b1)); // R2
  AST_V_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (v_cnt == '0));                                 // R2
endmodule

// File: rtl/vga_mode_decode.sv
module vga_mode_decode
  import vga_mode_pkg::*;
#(
  parameter int VW          = 10,
  parameter int V_SYNC      = 2,
  parameter int V350_BACK   = 60,
  parameter int V350_ACTIVE = 350,
  parameter int V350_FRONT  = 37,
  parameter int V400_BACK   = 35,
  parameter int V400_ACTIVE = 400,
  parameter int V400_FRONT  = 12,
  parameter int V480_BACK   = 33,
  parameter int V480_ACTIVE = 480,
  parameter int V480_FRONT  = 10
) (
  input  mode_t         mode,
  output logic [VW-1:0] v_act_start,
  output logic [VW-1:0] v_act_end,
  output logic [VW-1:0] v_last,
  output logic          hs_pos,
  output logic          vs_pos
);
  localparam int S350 = V_SYNC + V350_BACK;
  localparam int S400 = V_SYNC + V400_BACK;
  localparam int S480 = V_SYNC + V480_BACK;
  localparam int E350 = S350 + V350_ACTIVE;
  localparam int E400 = S400 + V400_ACTIVE;
  localparam int E480 = S480 + V480_ACTIVE;

  always_comb begin
    case (mode)
      MODE_L350: begin
        v_act_start = VW'(S350);
        v_act_end   = VW'(E350);
        v_last      = VW'(E350 + V350_FRONT - 1);
      end
      MODE_L400: begin
        v_act_start = VW'(S400);
        v_act_end   = VW'(E400);
        v_last      = VW'(E400 + V400_FRONT - 1);
      end
      default: begin
        v_act_start = VW'(S480);
        v_act_end   = VW'(E480);
        v_last      = VW'(E480 + V480_FRONT - 1);
      end
    endcase
    hs_pos = hs_active_high(mode);
    vs_pos = vs_active_high(mode);
  end
endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
  import vga_mode_pkg::*;
#(
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int H_ACTIVE = 640,
  parameter int HW       = 10,
  parameter int V_SYNC   = 2,
  parameter int VW       = 10,
  parameter int XW       = 10,
  parameter int YW       = 9,
  parameter int COLOR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic [HW-1:0]      h_cnt,
  input  logic [VW-1:0]      v_cnt,
  input  logic [VW-1:0]      v_act_start,
  input  logic [VW-1:0]      v_act_end,
  input  logic               hs_pos,
  input  logic               vs_pos,
  input  logic [COLOR_W-1:0] r_in,
  input  logic [COLOR_W-1:0] g_in,
  input  logic [COLOR_W-1:0] b_in,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [XW-1:0]      x_o,
  output logic [YW-1:0]      y_o,
  output logic [COLOR_W-1:0] r_o,
  output logic [COLOR_W-1:0] g_o,
  output logic [COLOR_W-1:0] b_o
);
  localparam logic [HW-1:0] H_SYNC_END = HW'(H_SYNC);
  localparam logic [HW-1:0] H_ACT_S    = HW'(H_SYNC + H_BACK);
  localparam logic [HW-1:0] H_ACT_E    = HW'(H_SYNC + H_BACK + H_ACTIVE);
  localparam logic [VW-1:0] V_SYNC_END = VW'(V_SYNC);

  logic          h_sync_act, v_sync_act, h_vis, v_vis, vis;
  logic [HW-1:0] x_full;
  logic [VW-1:0] y_full;

  always_comb begin
    h_sync_act = (h_cnt < H_SYNC_END);
    v_sync_act = (v_cnt < V_SYNC_END);
    h_vis      = (h_cnt >= H_ACT_S) && (h_cnt < H_ACT_E);
    v_vis      = (v_cnt >= v_act_start) && (v_cnt < v_act_end);
    vis        = h_vis && v_vis;
    x_full     = h_cnt - H_ACT_S;
    y_full     = v_cnt - v_act_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= ~hs_active_high(mode_sel);
      vsync_o <= ~vs_active_high(mode_sel);
      de_o    <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      r_o     <= '0;
      g_o     <= '0;
      b_o     <= '0;
    end else begin
      hsync_o <= hs_pos ? h_sync_act : ~h_sync_act;
      vsync_o <= vs_pos ? v_sync_act : ~v_sync_act;
      de_o    <= vis;
      x_o     <= vis ? XW'(x_full) : '0;
      y_o     <= vis ? YW'(y_full) : '0;
      r_o     <= vis ? r_in : '0;
      g_o     <= vis ? g_in : '0;
      b_o     <= vis ? b_in : '0;
    end
  end

  AST_DE_XY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (x_o == '0 && y_o == '0));                          // R5
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (r_o == '0 && g_o == '0 && b_o == '0));             // R6
  AST_SYNC_NO_DE: assert property (@(posedge clk) disable iff (rst)
    (hsync_o == hs_pos) |-> !de_o);                               // R1
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
  import vga_mode_pkg::*;
#(
  parameter int H_SYNC      = 96,
  parameter int H_BACK      = 48,
  parameter int H_ACTIVE    = 640,
  parameter int H_FRONT     = 16,
  parameter int V_SYNC      = 2,
  parameter int V350_BACK   = 60,
  parameter int V350_ACTIVE = 350,
  parameter int V350_FRONT  = 37,
  parameter int V400_BACK   = 35,
  parameter int V400_ACTIVE = 400,
  parameter int V400_FRONT  = 12,
  parameter int V480_BACK   = 33,
  parameter int V480_ACTIVE = 480,
  parameter int V480_FRONT  = 10,
  parameter int COLOR_W     = 4,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(imax3(V350_ACTIVE, V400_ACTIVE, V480_ACTIVE))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic [COLOR_W-1:0] red_in,
  input  logic [COLOR_W-1:0] green_in,
  input  logic [COLOR_W-1:0] blue_in,
  output logic               hsync,
  output logic               vsync,
  output logic               disp_en,
  output logic [XW-1:0]      pix_x,
  output logic [YW-1:0]      pix_y,
  output logic [COLOR_W-1:0] red_out,
  output logic [COLOR_W-1:0] green_out,
  output logic [COLOR_W-1:0] blue_out
);
  localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int V_TMAX  = imax3(V_SYNC + V350_BACK + V350_ACTIVE + V350_FRONT,
                                 V_SYNC + V400_BACK + V400_ACTIVE + V400_FRONT,
                                 V_SYNC + V480_BACK + V480_ACTIVE + V480_FRONT);
  localparam int VW      = $clog2(V_TMAX);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt, v_act_start, v_act_end, v_last;
  logic          line_end, frame_end, hs_pos, vs_pos;
  mode_t         mode_q;

  // Format latch: loaded in reset and at the frame wrap only.
  always_ff @(posedge clk) begin
    if (rst || frame_end) mode_q <= mode_t'(mode_sel);
  end

  vga_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) u_hcnt (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .line_end(line_end)
  );

  vga_mode_decode #(
    .VW(VW), .V_SYNC(V_SYNC),
    .V350_BACK(V350_BACK), .V350_ACTIVE(V350_ACTIVE), .V350_FRONT(V350_FRONT),
    .V400_BACK(V400_BACK), .V400_ACTIVE(V400_ACTIVE), .V400_FRONT(V400_FRONT),
    .V480_BACK(V480_BACK), .V480_ACTIVE(V480_ACTIVE), .V480_FRONT(V480_FRONT)
  ) u_dec (
    .mode(mode_q), .v_act_start(v_act_start), .v_act_end(v_act_end),
    .v_last(v_last), .hs_pos(hs_pos), .vs_pos(vs_pos)
  );

  vga_vcount #(.VW(VW)) u_vcnt (
    .clk(clk), .rst(rst), .line_end(line_end), .v_last(v_last),
    .v_cnt(v_cnt), .frame_end(frame_end)
  );

  vga_pixel_out #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_ACTIVE(H_ACTIVE), .HW(HW),
    .V_SYNC(V_SYNC), .VW(VW), .XW(XW), .YW(YW), .COLOR_W(COLOR_W)
  ) u_out (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .v_act_start(v_act_start), .v_act_end(v_act_end),
    .hs_pos(hs_pos), .vs_pos(vs_pos),
    .r_in(red_in), .g_in(green_in), .b_in(blue_in),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(disp_en),
    .x_o(pix_x), .y_o(pix_y),
    .r_o(red_out), .g_o(green_out), .b_o(blue_out)
  );

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(mode_q));                              // R7
endmodule

// File: tb/vga_timing_gen_test.sv
`timescale 1ns/1ps
module vga_timing_gen_test;
  localparam int HS = 4, HB = 3, HA = 8, HF = 2;
  localparam int HT = HS + HB + HA + HF;
  localparam int VS = 2;
  localparam int B0 = 3, A0 = 5, F0 = 2;
  localparam int B1 = 2, A1 = 6, F1 = 3;
  localparam int B2 = 4, A2 = 7, F2 = 1;
  localparam int CW = 4;
  localparam int NCYC = 9000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'b00;
  logic [CW-1:0] r_i = '0, g_i = '0, b_i = '0;
  logic          hsync, vsync, disp_en;
  logic [2:0]    pix_x, pix_y;
  logic [CW-1:0] r_o, g_o, b_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vga_timing_gen #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA), .H_FRONT(HF), .V_SYNC(VS),
    .V350_BACK(B0), .V350_ACTIVE(A0), .V350_FRONT(F0),
    .V400_BACK(B1), .V400_ACTIVE(A1), .V400_FRONT(F1),
    .V480_BACK(B2), .V480_ACTIVE(A2), .V480_FRONT(F2),
    .COLOR_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .red_in(r_i), .green_in(g_i), .blue_in(b_i),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .pix_x(pix_x), .pix_y(pix_y),
    .red_out(r_o), .green_out(g_o), .blue_out(b_o)
  );

  function automatic int vback(int m);
    return (m == 0) ? B0 : (m == 1) ? B1 : B2;
  endfunction
  function automatic int vact(int m);
    return (m == 0) ? A0 : (m == 1) ? A1 : A2;
  endfunction
  function automatic int vlast(int m);
    return VS + vback(m) + vact(m) + ((m == 0) ? F0 : (m == 1) ? F1 : F2) - 1;
  endfunction
  function automatic int hpos(int m);  // R3: 00 -> active-high
    return (m == 0) ? 1 : 0;
  endfunction
  function automatic int vpos(int m);  // R4: 01 -> active-high
    return (m == 1) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state (before the next rising edge)
  int mh = 0, mv = 0, mm = 0;
  int e_hs, e_vs, e_de, e_x, e_y, e_r, e_g, e_b;
  bit e_rst, valid = 0;
  bit changed_mid = 0;

  task automatic predict(bit r, int sel);
    int hv, vv, fe;
    e_rst = r;
    if (r) begin  // R8
      e_hs = 1 - hpos(sel); e_vs = 1 - vpos(sel);
      e_de = 0; e_x = 0; e_y = 0; e_r = 0; e_g = 0; e_b = 0;
      mh = 0; mv = 0; mm = sel;
      changed_mid = 0;
    end else begin
      hv = (mh >= HS + HB) && (mh < HS + HB + HA);
      vv = (mv >= VS + vback(mm)) && (mv < VS + vback(mm) + vact(mm));
      e_hs = (mh < HS) ? hpos(mm) : 1 - hpos(mm);
      e_vs = (mv < VS) ? vpos(mm) : 1 - vpos(mm);
      e_de = hv && vv;
      e_x = e_de ? mh - HS - HB : 0;
      e_y = e_de ? mv - VS - vback(mm) : 0;
      e_r = e_de ? int'(r_i) : 0;
      e_g = e_de ? int'(g_i) : 0;
      e_b = e_de ? int'(b_i) : 0;
      fe = (mh == HT - 1) && (mv == vlast(mm));
      if (sel != mm && !fe) changed_mid = 1;
      if (mh == HT - 1) begin
        mh = 0;
        mv = fe ? 0 : mv + 1;
      end else mh++;
      if (fe) begin mm = sel; changed_mid = 0; end
    end
  endtask

  task automatic compare;
    string vt;
    if (e_rst) begin
      chk("R8 hsync", hsync, e_hs);
      chk("R8 vsync", vsync, e_vs);
      chk("R8 de", disp_en, 0);
      chk("R8 xy", pix_x + pix_y, 0);
      chk("R8 rgb", r_o | g_o | b_o, 0);
    end else begin
      vt = (mm == 3) ? "R2 R4 R10 vsync" : changed_mid ? "R2 R4 R7 vsync" : "R2 R4 vsync";
      chk("R1 R3 R9 hsync", hsync, e_hs);
      chk(vt, vsync, e_vs);
      chk("R5 de", disp_en, e_de);
      chk("R5 x", pix_x, e_x);
      chk("R5 y", pix_y, e_y);
      chk("R6 R9 red", r_o, e_r);
      chk("R6 green", g_o, e_g);
      chk("R6 blue", b_o, e_b);
    end
  endtask

  initial begin
    int sel;
    bit r;
    void'($urandom(32'd20240611));
    sel = 0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (valid) compare();
      // directed schedule, then random
      if (c < 3)          begin r = 1; sel = 0; end
      else if (c < 1500)  begin r = 0; sel = (c < 100) ? 0 : 1; end  // R7 mid-frame change
      else if (c < 2500)  begin r = 0; sel = 2; end
      else if (c < 3500)  begin r = 0; sel = 3; end                  // R10
      else if (c < 3502)  begin r = 1; sel = 1; end                  // R8 mid-frame reset
      else begin
        r = ($urandom_range(0, 2999) == 0);
        if ($urandom_range(0, 149) == 0) sel = $urandom_range(0, 3);
      end
      rst = r; mode_sel = 2'(sel);
      r_i = CW'($urandom); g_i = CW'($urandom); b_i = CW'($urandom);
      predict(r, sel);
      valid = 1;
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * (NCYC + 1000));
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule